// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a four-level radix page table built from 4 KB pages. A walk starts from a root table page number given with the request. At each level the walker reads one 64-bit entry through a single request/response memory port. It then checks that entry's present and permission bits against the access type: write, user or instruction fetch. If the entry's accessed flag is clear, the walker writes the entry back with the flag set. On a write access it also sets the dirty flag of the final entry. This write-back finishes before the next level is read.

A walk ends with a one-cycle completion pulse. The pulse comes either with the translated physical address or with a fault flag and a two-bit cause code. The result stays on the output pins until the next walk is accepted. Only one walk runs at a time. A request is accepted only while the walker is idle.

Top module: `radix_walker`

## Requirements
- R1: The entry address at each level is the current table base (a 4 KB aligned page number placed in address bits 51:12) plus eight times a 9-bit index. The indices come from virtual address bits 47:39, 38:30, 29:21 and 20:12 for the first through the fourth level. The first table's page number is the request's root value, and each later table's page number is bits 51:12 of the entry read one level above.
- R2: If an entry has bit 0 (present) clear, the walk ends with a fault and cause 0. No further memory access follows, and that entry is not written.
- R3: On a write access, an entry with bit 1 (writable) clear at any level ends the walk with a fault and cause 1.
- R4: On a user access, an entry with bit 2 (user allowed) clear at any level ends the walk with a fault and cause 2.
- R5: On an instruction fetch, an entry with bit 63 (no-execute) set at any level ends the walk with a fault and cause 3. Bit 63 has no effect on non-fetch accesses. Within one entry the checks take priority in the order present, write, user, fetch. Levels are checked from the first level down.
- R6: After an entry passes its checks, it is written back to the same address with bit 5 (accessed) set, but only if bit 5 was clear. That write completes before the next level is read.
- R7: On a write access, the fourth-level entry is written back with bit 6 (dirty) set if bit 6 was clear. This happens in the same write as the accessed flag. Read and fetch accesses never set bit 6.
- R8: An entry whose accessed flag is already set, and that needs no dirty update, causes no memory write.
- R9: A successful walk returns bits 51:12 of the fourth-level entry concatenated with virtual address bits 11:0. The completion output is high for exactly one cycle per walk.
- R10: After reset the completion, fault and memory request outputs are low. A request presented while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (accepted only when idle) |
| reqVaddr | input | 48 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is made from user mode |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqRootPpn | input | 40 | Page number of the first-level table |
| memReqValid | output | 1 | Memory request, held until answered |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 52 | Byte address of the entry |
| memWdata | output | 64 | Updated entry for a write |
| memRspValid | input | 1 | One-cycle response; completes the held request |
| memRdata | input | 64 | Read data returned with the response |
| walkDone | output | 1 | One-cycle walk completion pulse |
| walkFault | output | 1 | Walk ended in a fault |
| faultCause | output | 2 | 0 absent, 1 write protect, 2 user protect, 3 no-execute |
| physAddr | output | 52 | Translated physical address |

## Verification
A memory request appears in the cycle after the walker enters a read or write step. The request stays stable until the response is consumed at a clock edge. The completion pulse follows one cycle after the deciding step: the evaluation of a faulting or final entry, or the response to the last write-back. Because the model memory adds a random delay of zero to two cycles, the bench does not assume a fixed walk length. It samples on falling edges until it sees the pulse. Only then does it compare the result, the numbers of reads and writes, and every updated entry against a reference walk computed over the same table image.

// File: rtl/walk_pkg.sv
package walk_pkg;
  parameter int LEVELS = 4;
  parameter int IDX_W  = 9;
  parameter int OFF_W  = 12;
  parameter int PPN_W  = 40;
  parameter int PTE_W  = 64;

  localparam int VA_W      = LEVELS * IDX_W + OFF_W;
  localparam int PA_W      = PPN_W + OFF_W;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int PTE_SHIFT = $clog2(PTE_W / 8);

  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_XD = PTE_W - 1;

  typedef enum logic [1:0] {
    CAUSE_ABSENT  = 2'd0,
    CAUSE_WRPROT  = 2'd1,
    CAUSE_USRPROT = 2'd2,
    CAUSE_NOEXEC  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EVAL, ST_WRITE} walkState_e;

  typedef struct packed {
    logic latchReq;
    logic capPte;
    logic advance;
    logic finishOk;
    logic finishFault;
  } walkStrobes_t;

  typedef struct packed {
    logic faultHit;
    logic needUpd;
    logic lastLvl;
  } walkFlags_t;
endpackage

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strobes,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqFetch,
  input  logic [PPN_W-1:0]  reqRootPpn,
  input  logic [PTE_W-1:0]  memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [PTE_W-1:0]  memWdata,
  output walkFlags_t        flags,
  output logic              walkDone,
  output logic              walkFault,
  output logic [1:0]        faultCause,
  output logic [PA_W-1:0]   physAddr
);
  logic [VA_W-1:0]  vaQ;
  logic             wrQ, usQ, fxQ;
  logic [PPN_W-1:0] baseQ;
  logic [LVL_W-1:0] lvlQ;
  logic [PTE_W-1:0] pteQ;
  logic             doneQ, faultQ;
  cause_e           causeQ;
  logic [PA_W-1:0]  paQ;

  logic [IDX_W-1:0] idxArr [LEVELS];
  logic [IDX_W-1:0] curIdx;
  logic             lastLvl, wrDeny, usDeny, xdDeny, absent;
  cause_e           causeNow;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxArr[g] = vaQ[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  assign curIdx  = idxArr[lvlQ];
  assign lastLvl = (lvlQ == LVL_W'(LEVELS - 1));
  assign memAddr = {baseQ, {OFF_W{1'b0}}} + (PA_W'(curIdx) << PTE_SHIFT);

  assign absent = !pteQ[BIT_P];
  assign wrDeny = wrQ && !pteQ[BIT_RW];
  assign usDeny = usQ && !pteQ[BIT_US];
  assign xdDeny = fxQ && pteQ[BIT_XD];

  always_comb begin
    if (absent)      causeNow = CAUSE_ABSENT;
    else if (wrDeny) causeNow = CAUSE_WRPROT;
    else if (usDeny) causeNow = CAUSE_USRPROT;
    else             causeNow = CAUSE_NOEXEC;
  end

  always_comb begin
    flags.faultHit = absent || wrDeny || usDeny || xdDeny;
    flags.needUpd  = !pteQ[BIT_A] || (lastLvl && wrQ && !pteQ[BIT_D]);
    flags.lastLvl  = lastLvl;
  end

  always_comb begin
    memWdata = pteQ;
    memWdata[BIT_A] = 1'b1;
    if (lastLvl && wrQ) memWdata[BIT_D] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      wrQ    <= 1'b0;
      usQ    <= 1'b0;
      fxQ    <= 1'b0;
      baseQ  <= '0;
      lvlQ   <= '0;
      pteQ   <= '0;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
      causeQ <= CAUSE_ABSENT;
      paQ    <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobes.latchReq) begin
        vaQ    <= reqVaddr;
        wrQ    <= reqWrite;
        usQ    <= reqUser;
        fxQ    <= reqFetch;
        baseQ  <= reqRootPpn;
        lvlQ   <= '0;
        faultQ <= 1'b0;
        causeQ <= CAUSE_ABSENT;
        paQ    <= '0;
      end
      if (strobes.capPte) pteQ <= memRdata;
      if (strobes.advance) begin
        baseQ <= pteQ[PA_W-1:OFF_W];
        lvlQ  <= lvlQ + 1'b1;
      end
      if (strobes.finishOk) begin
        doneQ  <= 1'b1;
        faultQ <= 1'b0;
        paQ    <= {pteQ[PA_W-1:OFF_W], vaQ[OFF_W-1:0]};
      end
      if (strobes.finishFault) begin
        doneQ  <= 1'b1;
        faultQ <= 1'b1;
        causeQ <= causeNow;
      end
    end
  end

  assign walkDone   = doneQ;
  assign walkFault  = faultQ;
  assign faultCause = causeQ;
  assign physAddr   = paQ;
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  walkFlags_t   flags,
  output walkStrobes_t strobes,
  output logic         memReqValid,
  output logic         memWrite
);
  walkState_e stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        if (memRspValid) begin
          strobes.capPte = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (flags.faultHit) begin
          strobes.finishFault = 1'b1;
          stateD = ST_IDLE;
        end else if (flags.needUpd) begin
          stateD = ST_WRITE;
        end else if (flags.lastLvl) begin
          strobes.finishOk = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobes.advance = 1'b1;
          stateD = ST_READ;
        end
      end
      ST_WRITE: begin
        if (memRspValid) begin
          if (flags.lastLvl) begin
            strobes.finishOk = 1'b1;
            stateD = ST_IDLE;
          end else begin
            strobes.advance = 1'b1;
            stateD = ST_READ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReqValid = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWrite    = (stateQ == ST_WRITE);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqFetch,
  input  logic [PPN_W-1:0]  reqRootPpn,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [PA_W-1:0]   memAddr,
  output logic [PTE_W-1:0]  memWdata,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRdata,
  output logic              walkDone,
  output logic              walkFault,
  output logic [1:0]        faultCause,
  output logic [PA_W-1:0]   physAddr
);
  walkStrobes_t strobes;
  walkFlags_t   flags;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .flags       (flags),
    .strobes     (strobes),
    .memReqValid (memReqValid),
    .memWrite    (memWrite)
  );

  walk_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .reqFetch   (reqFetch),
    .reqRootPpn (reqRootPpn),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .flags      (flags),
    .walkDone   (walkDone),
    .walkFault  (walkFault),
    .faultCause (faultCause),
    .physAddr   (physAddr)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk
  import walk_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [OFF_W-1:0] vaOff,
  input logic             memReqValid,
  input logic             memWrite,
  input logic             memRspValid,
  input logic [PA_W-1:0]  memAddr,
  input logic [PTE_W-1:0] memWdata,
  input logic             walkDone,
  input logic             walkFault,
  input logic [OFF_W-1:0] paOff
);
  logic             busyQ;
  logic [OFF_W-1:0] offQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      offQ  <= '0;
    end else if (reqValid && (!busyQ || walkDone)) begin
      busyQ <= 1'b1;
      offQ  <= vaOff;
    end else if (walkDone) begin
      busyQ <= 1'b0;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memAddr)
      && $stable(memWrite) && $stable(memWdata));

  p_wb_sets_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memWrite |-> memWdata[BIT_A] && memWdata[BIT_P]);

  p_entry_align_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[PTE_SHIFT-1:0] == '0);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !memReqValid);

  p_pa_offset_r9: assert property (@(posedge clk) disable iff (!rstN)
    walkDone && !walkFault |-> paOff == offQ);
endmodule

bind radix_walker walk_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .vaOff       (reqVaddr[walk_pkg::OFF_W-1:0]),
  .memReqValid (memReqValid),
  .memWrite    (memWrite),
  .memRspValid (memRspValid),
  .memAddr     (memAddr),
  .memWdata    (memWdata),
  .walkDone    (walkDone),
  .walkFault   (walkFault),
  .paOff       (physAddr[walk_pkg::OFF_W-1:0])
);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  localparam logic [63:0] FP  = 64'h1;
  localparam logic [63:0] FRW = 64'h2;
  localparam logic [63:0] FUS = 64'h4;
  localparam logic [63:0] FA  = 64'h20;
  localparam logic [63:0] FD  = 64'h40;
  localparam logic [63:0] FXD = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [47:0] reqVaddr = '0;
  logic        reqWrite = 1'b0, reqUser = 1'b0, reqFetch = 1'b0;
  logic [39:0] reqRootPpn = '0;
  logic        memReqValid, memWrite;
  logic [51:0] memAddr;
  logic [63:0] memWdata;
  logic        memRspValid = 1'b0;
  logic [63:0] memRdata = '0;
  logic        walkDone, walkFault;
  logic [1:0]  faultCause;
  logic [51:0] physAddr;

  always #4 clk = ~clk;

  radix_walker dut (.*);

  logic [63:0] mem [logic [51:0]];
  int nReads, nWrites;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [39:0] nextPage = 40'h100;

  logic        expFault;
  logic [1:0]  expCause;
  logic [51:0] expPa;
  int          expReads, expWrites, nUpd;
  logic [51:0] updAddr [4];
  logic [63:0] updVal [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] allocPage();
    nextPage = nextPage + 40'd1;
    return nextPage;
  endfunction

  function automatic logic [51:0] entryAddr(input logic [39:0] base, input logic [47:0] va, input int l);
    return {base, 12'h0} + {40'h0, va[12 + (3 - l) * 9 +: 9], 3'b000};
  endfunction

  task automatic buildPath(input logic [47:0] va, input logic [39:0] root,
                           input logic [63:0] fl [4], input logic [39:0] leaf);
    logic [39:0] base, child;
    base = root;
    for (int l = 0; l < 4; l++) begin
      child = (l == 3) ? leaf : allocPage();
      mem[entryAddr(base, va, l)] = (fl[l] & 64'h8000_0000_0000_0FFF) | {12'h0, child, 12'h0};
      base = child;
    end
  endtask

  task automatic modelWalk(input logic [47:0] va, input logic wr, us, fx, input logic [39:0] root);
    logic [39:0] base;
    logic [63:0] pte;
    logic [51:0] a;
    base = root;
    expFault = 0; expCause = 0; expPa = '0; expReads = 0; expWrites = 0; nUpd = 0;
    for (int l = 0; l < 4; l++) begin
      a = entryAddr(base, va, l);
      pte = mem.exists(a) ? mem[a] : 64'h0;
      expReads++;
      if (!pte[0])            begin expFault = 1; expCause = 2'd0; return; end
      if (wr && !pte[1])      begin expFault = 1; expCause = 2'd1; return; end
      if (us && !pte[2])      begin expFault = 1; expCause = 2'd2; return; end
      if (fx && pte[63])      begin expFault = 1; expCause = 2'd3; return; end
      if (!pte[5] || (l == 3 && wr && !pte[6])) begin
        updAddr[nUpd] = a;
        updVal[nUpd]  = pte | FA | ((l == 3 && wr) ? FD : 64'h0);
        nUpd++;
        expWrites++;
      end
      if (l == 3) expPa = {pte[51:12], va[11:0]};
      else        base = pte[51:12];
    end
  endtask

  task automatic runWalk(input logic [47:0] va, input logic wr, us, fx,
                         input logic [39:0] root, input string req, input bit intrude);
    int cnt;
    modelWalk(va, wr, us, fx, root);
    @(negedge clk);
    nReads = 0; nWrites = 0;
    reqValid = 1; reqVaddr = va; reqWrite = wr; reqUser = us; reqFetch = fx; reqRootPpn = root;
    @(negedge clk);
    reqValid = 0;
    cnt = 0;
    while (walkDone !== 1'b1 && cnt < 500) begin
      if (intrude && cnt == 2) begin
        reqValid = 1; reqVaddr = ~va; reqWrite = ~wr; reqRootPpn = root + 40'h55;
      end else begin
        reqValid = 0;
      end
      @(negedge clk);
      cnt++;
    end
    reqValid = 0;
    check(walkDone === 1'b1, "R9", "completion seen", 64'(walkDone), 64'h1);
    check(walkFault === expFault, req, "fault flag", 64'(walkFault), 64'(expFault));
    if (expFault) check(faultCause === expCause, req, "cause", 64'(faultCause), 64'(expCause));
    else          check(physAddr === expPa, req, "physical address", 64'(physAddr), 64'(expPa));
    check(nReads == expReads, req, "read count (R1 entry addressing)", 64'(nReads), 64'(expReads));
    check(nWrites == expWrites, req, "write-back count", 64'(nWrites), 64'(expWrites));
    for (int i = 0; i < nUpd; i++)
      check(mem[updAddr[i]] === updVal[i], req, "updated entry", mem[updAddr[i]], updVal[i]);
    @(negedge clk);
    check(walkDone === 1'b0, "R9", "completion lasts one cycle", 64'(walkDone), 64'h0);
  endtask

  // memory model: random 0..2 cycle response delay
  initial begin
    forever begin
      @(negedge clk);
      if (memRspValid) memRspValid = 0;
      else if (memReqValid) begin
        repeat ($urandom % 3) @(negedge clk);
        if (memWrite) begin
          mem[memAddr] = memWdata;
          nWrites++;
        end else begin
          memRdata = mem.exists(memAddr) ? mem[memAddr] : 64'h0;
          nReads++;
        end
        memRspValid = 1;
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [63:0] fl [4];
    logic [47:0] va;
    logic [39:0] root;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(walkDone === 1'b0, "R10", "done in reset", 64'(walkDone), 64'h0);
    check(walkFault === 1'b0, "R10", "fault in reset", 64'(walkFault), 64'h0);
    check(memReqValid === 1'b0, "R10", "mem request in reset", 64'(memReqValid), 64'h0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(memReqValid === 1'b0, "R10", "mem idle after reset", 64'(memReqValid), 64'h0);

    // R6/R7: all levels need the accessed flag, leaf needs dirty
    va = 48'h1234_5678_9ABC; root = allocPage();
    fl = '{FP|FRW|FUS, FP|FRW|FUS, FP|FRW|FUS, FP|FRW|FUS};
    buildPath(va, root, fl, 40'hAB_CDEF_0123);
    runWalk(va, 1, 1, 0, root, "R7", 0);
    // R8: flags already set, no writes
    va = 48'h0000_0000_0FFF; root = allocPage();
    fl = '{FP|FRW|FA, FP|FRW|FA, FP|FRW|FA, FP|FRW|FA|FD};
    buildPath(va, root, fl, 40'h1);
    runWalk(va, 1, 0, 0, root, "R8", 0);
    // R7: read never sets dirty
    va = 48'h7FFF_0000_1000; root = allocPage();
    fl = '{FP|FA, FP|FA, FP|FA, FP|FA};
    buildPath(va, root, fl, 40'h22);
    runWalk(va, 0, 0, 0, root, "R7", 0);
    // R2: absent at first level, then absent at third after two updates
    va = 48'hABCD_EF01_2345; root = allocPage();
    fl = '{FRW|FUS, FP, FP, FP};
    buildPath(va, root, fl, 40'h3);
    runWalk(va, 0, 0, 0, root, "R2", 0);
    root = allocPage();
    fl = '{FP, FP, FRW, FP};
    buildPath(va, root, fl, 40'h3);
    runWalk(va, 0, 0, 0, root, "R2", 0);
    // R3: write protect at second level
    va = 48'h0102_0304_0506; root = allocPage();
    fl = '{FP|FRW|FUS, FP|FUS, FP|FRW|FUS, FP|FRW|FUS};
    buildPath(va, root, fl, 40'h44);
    runWalk(va, 1, 1, 0, root, "R3", 0);
    // R4: user protect at leaf
    root = allocPage();
    fl = '{FP|FUS, FP|FUS, FP|FUS, FP};
    buildPath(va, root, fl, 40'h45);
    runWalk(va, 0, 1, 0, root, "R4", 0);
    // R5: no-execute on fetch, ignored on read, priority write over user
    root = allocPage();
    fl = '{FP, FP, FP|FXD, FP};
    buildPath(va, root, fl, 40'h46);
    runWalk(va, 0, 0, 1, root, "R5", 0);
    root = allocPage();
    buildPath(va, root, fl, 40'h47);
    runWalk(va, 0, 0, 0, root, "R5", 0);
    root = allocPage();
    fl = '{FP|FRW|FUS, FP, FP, FP};
    buildPath(va, root, fl, 40'h48);
    runWalk(va, 1, 1, 1, root, "R5", 0);
    // R9: extreme address bits
    va = 48'hFFFF_FFFF_FFFF; root = 40'hFF_FFFF_FF00;
    fl = '{FP|FRW, FP|FRW, FP|FRW, FP|FRW};
    buildPath(va, root, fl, 40'hFF_FFFF_FFFF);
    runWalk(va, 0, 0, 0, root, "R9", 0);
    // R10: request during a walk is ignored
    va = 48'h5555_AAAA_5555; root = allocPage();
    fl = '{FP|FRW|FUS, FP|FRW|FUS, FP|FRW|FUS, FP|FRW|FUS};
    buildPath(va, root, fl, 40'h99);
    runWalk(va, 0, 0, 0, root, "R10", 1);

    // random walks (R1 addressing exercised on every level)
    for (int t = 0; t < 300; t++) begin
      va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      root = allocPage();
      for (int l = 0; l < 4; l++) begin
        fl[l] = (($urandom % 12) != 0 ? FP : 64'h0) | (($urandom % 4) != 0 ? FRW : 64'h0)
              | (($urandom % 4) != 0 ? FUS : 64'h0) | (($urandom % 2) != 0 ? FA : 64'h0)
              | (($urandom % 2) != 0 ? FD : 64'h0) | (($urandom % 5) == 0 ? FXD : 64'h0);
      end
      buildPath(va, root, fl, {$urandom, $urandom} & 40'hFF_FFFF_FFFF);
      runWalk(va, 1'($urandom), 1'($urandom), 1'($urandom), root, "R1", 0);
    end
    finish();
  end
endmodule